// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This engine copies a fixed-length run of bytes from a page of the system address space into the sprite attribute memory. A single write to its start input supplies the high byte of the source address. The low byte is always zero. The engine then fetches the bytes one at a time at a fixed pace and writes each one into attribute memory, starting at offset zero. Source pages in the top eighth of the address space are folded down into the region just below it before use.

While a copy is running, the engine shows a busy flag and its current source address. An external address decoder uses these to block processor accesses that would collide with the copy. The engine drives its own read requests onto the system bus. The bus returns read data in the same cycle, and the engine forwards that data straight onto the attribute-memory write port. A new start while a copy is running abandons the pending step and begins again from the new page. A one-cycle done pulse marks the end of a copy that was allowed to finish.

Top module: `attr_dma_engine`

## Requirements
- R1: After reset, busy_o, rd_req_o, wr_en_o and done_o are all low.
- R2: A start pulse sampled at a clock edge makes busy_o high from the next cycle. While busy, src_addr_o equals {page, 8'h00} plus the number of bytes already written.
- R3: A page value of 8'hE0 or above is ANDed with 8'hDF before use. For example, 8'hFE becomes 8'hDE and 8'hE0 becomes 8'hC0. Pages below 8'hE0 are used unchanged.
- R4: The first read and write strobe occurs in the cycle that ends START_LAT clock edges after the start edge.
- R5: Each later strobe follows the previous one after exactly PITCH cycles. A copy makes exactly LEN strobes.
- R6: In strobe number k (counting from 0), rd_addr_o is the source base plus k and wr_addr_o is k. In the same cycle, wr_data_o equals rd_data_i, and rd_req_o and wr_en_o are both high.
- R7: busy_o stays high from the start edge until the clock edge that commits the last write, then falls.
- R8: done_o is high for exactly the one cycle that follows the clock edge committing the last write.
- R9: A start taken while busy restarts the copy. The new page, a zero destination, the full count and a fresh START_LAT latency all apply.
- R10: No strobe is issued in a cycle in which start_i is high, even if a step was due in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start/restart strobe, one cycle |
| page_i | input | 8 | High byte of the source address, sampled with start_i |
| rd_req_o | output | 1 | System bus read request |
| rd_addr_o | output | 16 | System bus read address |
| rd_data_i | input | 8 | Read data returned in the same cycle |
| wr_en_o | output | 1 | Attribute memory write strobe |
| wr_addr_o | output | DST_W (8) | Attribute memory write offset |
| wr_data_o | output | 8 | Attribute memory write data |
| busy_o | output | 1 | Copy in progress |
| src_addr_o | output | 16 | Current source address, for conflict blocking |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The main instance is built with LEN=5, START_LAT=3 and PITCH=2. With this configuration a full copy takes about a dozen cycles, so the bench can sweep all 256 page values. The sweep includes every folded page from 8'hE0 upward and every restart offset from the start edge to past completion, and restarts land on strobe cycles as well as between them. A second instance uses the defaults (160 bytes, 8-cycle latency, 4-cycle pitch). It confirms the full-length timing, the fold on a real copy and a mid-copy restart. Each instance checks every output against values the bench derives arithmetically from the cycle count since the last start.

// File: rtl/attr_dma_pkg.sv
package attr_dma_pkg;

    typedef logic [15:0] sys_addr_t;
    typedef logic [7:0]  byte_t;

    localparam byte_t FOLD_FROM = 8'hE0;
    localparam byte_t FOLD_MASK = 8'hDF;

    // Pages in the top region are folded down before use.
    function automatic byte_t fold_page(input byte_t page);
        return (page >= FOLD_FROM) ? (page & FOLD_MASK) : page;
    endfunction

endpackage

// File: rtl/attr_dma_pacer.sv
module attr_dma_pacer #(
    parameter int START_LAT = 8,
    parameter int PITCH     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic step_o
);
    localparam int SPAN  = (START_LAT > PITCH) ? START_LAT : PITCH;
    localparam int TMR_W = $clog2(SPAN + 1);

    typedef struct packed {
        logic [TMR_W-1:0] timer;
    } pacer_t;

    pacer_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        step_o  = run_i && (state_q.timer == '0) && !restart_i;
        if (restart_i) begin
            state_d.timer = TMR_W'(START_LAT - 1);
        end else if (run_i) begin
            if (state_q.timer == '0) state_d.timer = TMR_W'(PITCH - 1);
            else                     state_d.timer = state_q.timer - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_step_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> run_i);

    generate
        if (PITCH > 1) begin : g_gap
            assert_step_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                step_o |=> !step_o);
        end
    endgenerate

endmodule

// File: rtl/attr_dma_cursor.sv
module attr_dma_cursor
    import attr_dma_pkg::*;
#(
    parameter int LEN   = 160,
    parameter int DST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  sys_addr_t        base_i,
    input  logic             step_i,
    output sys_addr_t        src_o,
    output logic [DST_W-1:0] dst_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(LEN + 1);

    typedef struct packed {
        sys_addr_t        src;
        logic [DST_W-1:0] dst;
        logic [CNT_W-1:0] remain;
        logic             done;
    } cursor_t;

    cursor_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (restart_i) begin
            state_d.src    = base_i;
            state_d.dst    = '0;
            state_d.remain = CNT_W'(LEN);
        end else if (step_i) begin
            state_d.src    = state_q.src + 16'd1;
            state_d.dst    = state_q.dst + 1'b1;
            state_d.remain = state_q.remain - 1'b1;
            state_d.done   = (state_q.remain == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign src_o  = state_q.src;
    assign dst_o  = state_q.dst;
    assign busy_o = (state_q.remain != '0);
    assign done_o = state_q.done;

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.remain <= CNT_W'(LEN));

    assert_restart_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state_q.remain == CNT_W'(LEN)) && (state_q.src == $past(base_i))
                      && (state_q.dst == '0));

    assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i) |=> (state_q.src == $past(state_q.src) + 16'd1)
                                   && (state_q.remain == $past(state_q.remain) - 1'b1));

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(step_i)));

endmodule

// File: rtl/attr_dma_engine.sv
module attr_dma_engine
    import attr_dma_pkg::*;
#(
    parameter int LEN       = 160,
    parameter int START_LAT = 8,
    parameter int PITCH     = 4,
    parameter int DST_W     = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       page_i,
    output logic             rd_req_o,
    output logic [15:0]      rd_addr_o,
    input  logic [7:0]       rd_data_i,
    output logic             wr_en_o,
    output logic [DST_W-1:0] wr_addr_o,
    output logic [7:0]       wr_data_o,
    output logic             busy_o,
    output logic [15:0]      src_addr_o,
    output logic             done_o
);
    sys_addr_t        base_w;
    sys_addr_t        src_w;
    logic [DST_W-1:0] dst_w;
    logic             step_w;
    logic             busy_w;
    logic             done_w;

    assign base_w = {fold_page(page_i), 8'h00};

    attr_dma_pacer #(
        .START_LAT (START_LAT),
        .PITCH     (PITCH)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .run_i     (busy_w),
        .step_o    (step_w)
    );

    attr_dma_cursor #(
        .LEN   (LEN),
        .DST_W (DST_W)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .base_i    (base_w),
        .step_i    (step_w),
        .src_o     (src_w),
        .dst_o     (dst_w),
        .busy_o    (busy_w),
        .done_o    (done_w)
    );

    assign rd_req_o   = step_w;
    assign rd_addr_o  = src_w;
    assign wr_en_o    = step_w;
    assign wr_addr_o  = dst_w;
    assign wr_data_o  = rd_data_i;
    assign busy_o     = busy_w;
    assign src_addr_o = src_w;
    assign done_o     = done_w;

    assert_src_below_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (src_addr_o < 16'hE000));

    assert_no_strobe_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !wr_en_o);

endmodule

// File: tb/attr_dma_scoreboard.sv
module attr_dma_scoreboard #(
    parameter int LEN   = 5,
    parameter int LAT   = 3,
    parameter int PITCH = 2,
    parameter int DST_W = 3
) (
    input logic             clk,
    input logic             en,
    input logic             start_i,
    input logic [7:0]       page_i,
    input logic             rd_req,
    input logic [15:0]      rd_addr,
    input logic [7:0]       rd_data,
    input logic             wr_en,
    input logic [DST_W-1:0] wr_addr,
    input logic [7:0]       wr_data,
    input logic             busy,
    input logic [15:0]      src_addr,
    input logic             done
);
    localparam int LAST = LAT - 1 + (LEN - 1) * PITCH;

    int   checks = 0;
    int   fails  = 0;
    int   t      = 0;
    bit   active = 0;
    bit   folded = 0;
    int   base   = 0;
    int   rel, k, n, exp_busy, exp_done, exp_str;
    bit   slot;
    string tag;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, t);
        end
    endtask

    // Cycle count since the last start edge; fold per R3.
    always @(posedge clk) begin
        if (en) begin
            if (start_i) begin
                active <= 1;
                t      <= 0;
                folded <= (page_i >= 8'hE0);
                base   <= int'((page_i >= 8'hE0) ? (page_i & 8'hDF) : page_i) * 256;
            end else if (active) begin
                if (t == LAST + 1) active <= 0;
                else               t <= t + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (en) begin
            rel  = t - (LAT - 1);
            slot = active && rel >= 0 && (rel % PITCH) == 0 && (rel / PITCH) < LEN;
            k    = (rel >= 0) ? rel / PITCH : 0;
            exp_str  = (slot && !start_i) ? 1 : 0;
            exp_busy = (active && t <= LAST) ? 1 : 0;
            exp_done = (active && t == LAST + 1) ? 1 : 0;
            n        = (t < LAT) ? 0 : (t - LAT) / PITCH + 1;
            if (slot && start_i) tag = "R10";
            else if (k == 0)     tag = "R4";
            else                 tag = "R5";
            chk(tag, int'(rd_req), exp_str);
            chk(tag, int'(wr_en), exp_str);
            if (exp_str == 1 && rd_req) begin
                chk("R6", int'(rd_addr), base + k);
                chk("R6", int'(wr_addr), k);
                chk("R6", int'(wr_data), int'(rd_data));
            end
            chk("R7", int'(busy), exp_busy);
            chk("R8", int'(done), exp_done);
            if (exp_busy == 1)
                chk(folded ? "R3" : "R2", int'(src_addr), base + n);
        end
    end

endmodule

// File: tb/test_attr_dma_engine.sv
`timescale 1ns/1ps
module test_attr_dma_engine;

    localparam int S_LEN = 5, S_LAT = 3, S_PITCH = 2, S_DW = 3;
    localparam int F_LEN = 160, F_LAT = 8, F_PITCH = 4, F_DW = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic en = 0;
    logic start_s = 0, start_f = 0;
    logic [7:0] page_s = 0, page_f = 0;

    logic s_req, s_wen, s_busy, s_done;
    logic [15:0] s_raddr, s_src;
    logic [7:0] s_rdata, s_wdata;
    logic [S_DW-1:0] s_waddr;

    logic f_req, f_wen, f_busy, f_done;
    logic [15:0] f_raddr, f_src;
    logic [7:0] f_rdata, f_wdata;
    logic [F_DW-1:0] f_waddr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign s_rdata = s_raddr[7:0] ^ 8'h3C;
    assign f_rdata = f_raddr[7:0] ^ 8'hA5;

    attr_dma_engine #(.LEN(S_LEN), .START_LAT(S_LAT), .PITCH(S_PITCH)) i_attr_dma_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_s), .page_i(page_s),
        .rd_req_o(s_req), .rd_addr_o(s_raddr), .rd_data_i(s_rdata),
        .wr_en_o(s_wen), .wr_addr_o(s_waddr), .wr_data_o(s_wdata),
        .busy_o(s_busy), .src_addr_o(s_src), .done_o(s_done));

    attr_dma_engine i_attr_dma_engine_full (
        .clk(clk), .rst_n(rst_n), .start_i(start_f), .page_i(page_f),
        .rd_req_o(f_req), .rd_addr_o(f_raddr), .rd_data_i(f_rdata),
        .wr_en_o(f_wen), .wr_addr_o(f_waddr), .wr_data_o(f_wdata),
        .busy_o(f_busy), .src_addr_o(f_src), .done_o(f_done));

    attr_dma_scoreboard #(.LEN(S_LEN), .LAT(S_LAT), .PITCH(S_PITCH), .DST_W(S_DW)) i_sb_small (
        .clk(clk), .en(en), .start_i(start_s), .page_i(page_s),
        .rd_req(s_req), .rd_addr(s_raddr), .rd_data(s_rdata), .wr_en(s_wen),
        .wr_addr(s_waddr), .wr_data(s_wdata), .busy(s_busy), .src_addr(s_src), .done(s_done));

    attr_dma_scoreboard #(.LEN(F_LEN), .LAT(F_LAT), .PITCH(F_PITCH), .DST_W(F_DW)) i_sb_full (
        .clk(clk), .en(en), .start_i(start_f), .page_i(page_f),
        .rd_req(f_req), .rd_addr(f_raddr), .rd_data(f_rdata), .wr_en(f_wen),
        .wr_addr(f_waddr), .wr_data(f_wdata), .busy(f_busy), .src_addr(f_src), .done(f_done));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic trig_s(input logic [7:0] p);
        @(posedge clk); #1;
        start_s = 1; page_s = p;
        @(posedge clk); #1;
        start_s = 0;
    endtask

    task automatic trig_f(input logic [7:0] p);
        @(posedge clk); #1;
        start_f = 1; page_f = p;
        @(posedge clk); #1;
        start_f = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d",
                     checks + i_sb_small.checks + i_sb_full.checks,
                     fails + i_sb_small.fails + i_sb_full.fails);
            $finish;
        end
    endtask

    initial begin
        #(1_500_000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        // R1: outputs idle during and right after reset
        repeat (3) @(negedge clk);
        chk("R1", int'(s_busy), 0); chk("R1", int'(s_req), 0);
        chk("R1", int'(s_wen), 0);  chk("R1", int'(s_done), 0);
        chk("R1", int'(f_busy), 0); chk("R1", int'(f_wen), 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R1", int'(s_busy), 0); chk("R1", int'(s_done), 0);
        chk("R1", int'(f_busy), 0); chk("R1", int'(f_req), 0);
        en = 1;

        // R2/R3/R4..R8: every page value on the small instance
        for (int p = 0; p < 256; p++) begin
            trig_s(8'(p));
            cycles(14);
        end

        // R9/R10: restart at every offset, on and off strobe cycles
        for (int d = 0; d < 14; d++) begin
            trig_s(8'h40);
            cycles(d);
            trig_s(8'(8'h80 + d * 8));
            cycles(14);
        end

        // R9: start held high for several cycles with changing pages
        @(posedge clk); #1;
        start_s = 1; page_s = 8'h11;
        @(posedge clk); #1 page_s = 8'hF3;
        @(posedge clk); #1 page_s = 8'hE7;
        @(posedge clk); #1 start_s = 0;
        cycles(16);

        // Default configuration: full copy, folded copy, mid-copy restart
        trig_f(8'hC1);
        cycles(660);
        trig_f(8'hFE);
        cycles(300);
        trig_f(8'h05);
        cycles(660);

        cycles(4);
        report();
    end

endmodule